// File: doc/BRIEF.md
# Multiplexed-Address DRAM Strobe Controller with Refresh

This block sits between a host and a dynamic memory whose row and column addresses share one set of pins. The host offers a full word address, a direction and (for writes) a data word through a valid/ready handshake. The controller cuts the address into an upper row part and a lower column part. It places them on the shared bus one after the other, marking each with its own active-low strobe: the row strobe first, then the column strobe. It drives the memory's output-enable and write-enable lines and hands read data back with a one-cycle valid pulse.

The memory's cells lose charge, so the block keeps a free-running interval timer and a row counter of its own. Each time the timer expires, a refresh becomes pending. It is carried out as soon as any access in flight has ended, and before any further host request. A refresh is a row-strobe-only cycle that uses the counter's row. The counter then moves on to the next row and wraps after the last one. While a refresh is pending or running, the host sees ready low.

The data lines are split into a read input, a write output and an output-drive enable, so the block can sit behind any pad ring.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every strobe and enable to the memory (`dram_ras_n`, `dram_cas_n`, `dram_oe_n`, `dram_we_n`) is high, `dram_dq_oe` and `rd_valid` are 0, and `req_ready` is 1.
- R2: An accepted request runs four phases in the cycles after acceptance. In phase 1 the row is on the bus with both strobes high. In phase 2 the row stays on the bus with the row strobe low. In phases 3 and 4 the column is on the bus with both strobes low. In the next cycle both strobes are high again. The column address is held steady while the column strobe stays low.
- R3: On a read, write-enable stays high through all four phases and output-enable is low in phase 4 only. `rd_valid` pulses for one cycle right after phase 4, with `rd_data` equal to the word the memory drove at the end of phase 4.
- R4: On a write, write-enable is low through all four phases, `dram_dq_oe` is 1 and `dram_dq_out` carries the host word during phases 3 and 4, and output-enable stays high.
- R5: The column strobe is never low while the row strobe is high.
- R6: A refresh is due every `RFSH_INTERVAL` cycles. It lasts three cycles: the row on the bus with the strobes high, then two cycles with the row strobe low. The column strobe stays high throughout.
- R7: Refresh rows start at 0 after reset, go up by one per refresh and wrap from 2^ROW_W-1 back to 0.
- R8: A due refresh waits only for the access in flight and runs before any further host request. `req_ready` is low whenever the row strobe is low or a refresh is pending, so refresh is never starved by continuous host traffic.
- R9: The row is address bits [ADDR_W-1:COL_W] and the column is bits [COL_W-1:0]. The narrower of the two is zero-extended in the upper bits of the `MUXA_W`-bit bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Full word address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted on this edge when valid |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DATA_W | Read data |
| dram_addr | output | MUXA_W | Shared row/column address bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | DATA_W | Data toward the memory |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | DATA_W | Data from the memory |

## Verification
The main function is first tried with a directed sweep that writes every address once. This fills the memory model and separates row bits from column bits, which a swapped or mis-padded split would mix up. It then runs a seeded random mix of back-to-back reads and writes with no idle gaps, so refreshes must wedge in between host accesses. That run tells a correct priority and wait rule apart from starvation or an interrupted access. The extreme addresses (all zeros, all ones) and a read-after-write to the same word are added as directed cases, and every refresh is traced to confirm its row order, its wrap and its spacing.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ACC1,
      ST_ACC2,
      ST_ACC3,
      ST_ACC4,
      ST_REF1,
      ST_REF2,
      ST_REF3
   } seq_state_t;
endpackage

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
   parameter int ROW_W  = 4,
   parameter int COL_W  = 3,
   parameter int MUXA_W = 4
) (
   input  logic [ROW_W-1:0]  row_i,
   input  logic [COL_W-1:0]  col_i,
   input  logic              sel_col_i,
   output logic [MUXA_W-1:0] bus_o
);
   logic [MUXA_W-1:0] row_ext;
   logic [MUXA_W-1:0] col_ext;

   // pad whichever half is narrower than the shared bus
   generate
      if (ROW_W == MUXA_W) begin : g_row_full
         assign row_ext = row_i;
      end else begin : g_row_pad
         assign row_ext = {{(MUXA_W-ROW_W){1'b0}}, row_i};
      end
      if (COL_W == MUXA_W) begin : g_col_full
         assign col_ext = col_i;
      end else begin : g_col_pad
         assign col_ext = {{(MUXA_W-COL_W){1'b0}}, col_i};
      end
   endgenerate

   assign bus_o = sel_col_i ? col_ext : row_ext;
endmodule

// File: rtl/dram_rfsh_sched.sv
module dram_rfsh_sched #(
   parameter int ROW_W    = 4,
   parameter int INTERVAL = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             done_i,
   output logic             pend_o,
   output logic [ROW_W-1:0] row_o
);
   localparam int TW = $clog2(INTERVAL);

   generate
      if (INTERVAL < 16) begin : g_bad_interval
         $error("refresh interval must cover an access plus a refresh");
      end
   endgenerate

   logic [TW-1:0] tmr_q;
   logic          tick;

   assign tick = (tmr_q == TW'(INTERVAL-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_q  <= '0;
         pend_o <= 1'b0;
      end else begin
         tmr_q <= tick ? '0 : tmr_q + 1'b1;
         if (start_i) pend_o <= 1'b0;
         if (tick)    pend_o <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      row_o <= '0;
      else if (done_i) row_o <= row_o + 1'b1;
   end

   assert_row_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> (row_o == $past(row_o) + 1'b1));
   assert_pend_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o && !start_i) |=> pend_o);
   assert_timer_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_q <= TW'(INTERVAL-1));
endmodule

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl
   import dram_ctrl_pkg::*;
#(
   parameter  int ROW_W         = 4,
   parameter  int COL_W         = 3,
   parameter  int DATA_W        = 8,
   parameter  int RFSH_INTERVAL = 64,
   localparam int ADDR_W        = ROW_W + COL_W,
   localparam int MUXA_W        = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [MUXA_W-1:0] dram_addr,
   output logic              dram_ras_n,
   output logic              dram_cas_n,
   output logic              dram_oe_n,
   output logic              dram_we_n,
   output logic [DATA_W-1:0] dram_dq_out,
   output logic              dram_dq_oe,
   input  logic [DATA_W-1:0] dram_dq_in
);
   generate
      if (ROW_W < 1 || COL_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("row, column and data widths must be positive");
      end
   endgenerate

   seq_state_t        state_q, state_d;
   logic [ROW_W-1:0]  row_q;
   logic [COL_W-1:0]  col_q;
   logic              wr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              rfsh_pend, rfsh_start, rfsh_done;
   logic [ROW_W-1:0]  rfsh_row;
   logic              in_acc, in_ref, col_phase;

   assign req_ready  = (state_q == ST_IDLE) && !rfsh_pend;
   assign rfsh_start = (state_q == ST_IDLE) && rfsh_pend;
   assign rfsh_done  = (state_q == ST_REF3);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (rfsh_pend)      state_d = ST_REF1;
                  else if (req_valid) state_d = ST_ACC1;
         ST_ACC1: state_d = ST_ACC2;
         ST_ACC2: state_d = ST_ACC3;
         ST_ACC3: state_d = ST_ACC4;
         ST_ACC4: state_d = ST_IDLE;
         ST_REF1: state_d = ST_REF2;
         ST_REF2: state_d = ST_REF3;
         ST_REF3: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         row_q   <= '0;
         col_q   <= '0;
         wr_q    <= 1'b0;
         wdata_q <= '0;
      end else begin
         state_q <= state_d;
         if (req_valid && req_ready) begin
            row_q   <= req_addr[ADDR_W-1:COL_W];
            col_q   <= req_addr[COL_W-1:0];
            wr_q    <= req_write;
            wdata_q <= req_wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= (state_q == ST_ACC4) && !wr_q;
         if ((state_q == ST_ACC4) && !wr_q) rd_data <= dram_dq_in;
      end
   end

   assign in_acc    = (state_q == ST_ACC1) || (state_q == ST_ACC2) ||
                      (state_q == ST_ACC3) || (state_q == ST_ACC4);
   assign in_ref    = (state_q == ST_REF1) || (state_q == ST_REF2) ||
                      (state_q == ST_REF3);
   assign col_phase = (state_q == ST_ACC3) || (state_q == ST_ACC4);

   assign dram_ras_n  = !((in_acc && state_q != ST_ACC1) ||
                          (in_ref && state_q != ST_REF1));
   assign dram_cas_n  = !col_phase;
   assign dram_oe_n   = !((state_q == ST_ACC4) && !wr_q);
   assign dram_we_n   = !(in_acc && wr_q);
   assign dram_dq_oe  = col_phase && wr_q;
   assign dram_dq_out = wdata_q;

   dram_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .MUXA_W(MUXA_W)) i_addr_mux (
      .row_i     (in_ref ? rfsh_row : row_q),
      .col_i     (col_q),
      .sel_col_i (col_phase),
      .bus_o     (dram_addr)
   );

   dram_rfsh_sched #(.ROW_W(ROW_W), .INTERVAL(RFSH_INTERVAL)) i_rfsh (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (rfsh_start),
      .done_i  (rfsh_done),
      .pend_o  (rfsh_pend),
      .row_o   (rfsh_row)
   );

   assert_cas_under_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_cas_n |-> !dram_ras_n);
   assert_oe_read_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_oe_n |-> (dram_we_n && !dram_cas_n));
   assert_rd_after_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(!dram_oe_n));
   assert_col_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_addr));
   assert_drive_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dram_dq_oe |-> (!dram_we_n && !dram_cas_n && dram_oe_n));
   assert_ready_only_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (dram_ras_n && !rfsh_pend));
endmodule

// File: tb/test_dram_strobe_ctrl.sv
module test_dram_strobe_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int ROW_W = 4;
   localparam int COL_W = 3;
   localparam int DATA_W = 8;
   localparam int RFSH = 40;
   localparam int ADDR_W = ROW_W + COL_W;
   localparam int MUXA_W = (ROW_W > COL_W) ? ROW_W : COL_W;
   localparam int WORDS = 1 << ADDR_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic req_ready, rd_valid;
   logic [DATA_W-1:0] rd_data, dram_dq_out, dram_dq_in;
   logic [MUXA_W-1:0] dram_addr;
   logic dram_ras_n, dram_cas_n, dram_oe_n, dram_we_n, dram_dq_oe;

   int n_tests = 0, n_fail = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dram_strobe_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
                      .RFSH_INTERVAL(RFSH)) i_dram_strobe_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
      .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_oe_n(dram_oe_n),
      .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
      .dram_dq_in(dram_dq_in));

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // ---------------- memory model and refresh monitor ----------------
   logic [DATA_W-1:0] mem [WORDS];
   logic [DATA_W-1:0] shadow [WORDS];
   logic [ROW_W-1:0] m_row = '0;
   logic [COL_W-1:0] m_col = '0;
   logic ras_prev = 1'b1, cas_prev = 1'b1, cas_seen = 1'b0;
   int ras_lo = 0, cyc = 0, last_ref = -1, n_ref = 0;
   logic [ROW_W-1:0] exp_ref = '0;

   assign dram_dq_in = (!dram_cas_n && !dram_oe_n) ? mem[{m_row, m_col}] : '0;

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (!dram_ras_n) begin
            if (ras_prev) begin
               m_row = dram_addr[ROW_W-1:0];
               cas_seen = 1'b0;
               ras_lo = 0;
            end
            ras_lo++;
            if (req_ready) chk(0, "R8", "ready while row strobe low", 1, 0);
         end
         if (!dram_cas_n && cas_prev) begin
            chk(!dram_ras_n, "R5", "column strobe under row strobe", dram_ras_n, 0);
            m_col = dram_addr[COL_W-1:0];
            chk(dram_addr[MUXA_W-1:COL_W] == '0, "R9", "column pad bits",
                dram_addr, dram_addr[COL_W-1:0]);
            cas_seen = 1'b1;
            if (!dram_we_n) mem[{m_row, m_col}] = dram_dq_out;
         end
         if (dram_ras_n && !ras_prev && !cas_seen) begin
            n_ref++;
            chk(m_row == exp_ref, "R7", "refresh row", m_row, exp_ref);
            chk(ras_lo == 2, "R6", "refresh strobe length", ras_lo, 2);
            if (last_ref >= 0)
               chk((cyc - last_ref) <= RFSH + 6 && (cyc - last_ref) >= RFSH - 6,
                   "R8", "refresh spacing", cyc - last_ref, RFSH);
            else
               chk(cyc <= RFSH + 10, "R6", "first refresh time", cyc, RFSH);
            last_ref = cyc;
            exp_ref = exp_ref + 1'b1;
         end
         ras_prev = dram_ras_n;
         cas_prev = dram_cas_n;
      end
   end

   // ---------------- host driver with phase checks ----------------
   task automatic access(input bit wr, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] d);
      logic [MUXA_W-1:0] row_bus = MUXA_W'(a[ADDR_W-1:COL_W]);
      logic [MUXA_W-1:0] col_bus = MUXA_W'(a[COL_W-1:0]);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      chk(dram_ras_n && dram_cas_n, "R2", "phase1 strobes high", dram_ras_n, 1);
      chk(dram_addr == row_bus, "R9", "phase1 row", dram_addr, row_bus);
      chk(dram_we_n == !wr, wr ? "R4" : "R3", "phase1 write enable", dram_we_n, !wr);
      @(negedge clk);
      chk(!dram_ras_n && dram_cas_n, "R2", "phase2 row strobe", dram_ras_n, 0);
      chk(dram_addr == row_bus, "R2", "phase2 row held", dram_addr, row_bus);
      @(negedge clk);
      chk(!dram_cas_n && !dram_ras_n, "R2", "phase3 strobes", dram_cas_n, 0);
      chk(dram_addr == col_bus, "R9", "phase3 column", dram_addr, col_bus);
      chk(dram_oe_n, "R3", "phase3 output enable high", dram_oe_n, 1);
      if (wr) chk(dram_dq_oe && dram_dq_out == d, "R4", "phase3 write data",
                  dram_dq_out, d);
      @(negedge clk);
      chk(!dram_cas_n && dram_addr == col_bus, "R2", "phase4 column held",
          dram_addr, col_bus);
      chk(dram_oe_n == wr, "R3", "phase4 output enable", dram_oe_n, wr);
      chk(dram_we_n == !wr, wr ? "R4" : "R3", "phase4 write enable", dram_we_n, !wr);
      if (wr) chk(dram_dq_oe, "R4", "phase4 drive", dram_dq_oe, 1);
      @(negedge clk);
      chk(dram_ras_n && dram_cas_n, "R2", "strobes released", dram_cas_n, 1);
      if (wr) begin
         chk(!rd_valid, "R4", "no read pulse on write", rd_valid, 0);
         shadow[a] = d;
      end else begin
         chk(rd_valid, "R3", "read valid pulse", rd_valid, 1);
         chk(rd_data == shadow[a], "R3", "read data", rd_data, shadow[a]);
      end
   endtask

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'h1CE5);
      repeat (3) @(negedge clk);
      chk(dram_ras_n && dram_cas_n && dram_oe_n && dram_we_n, "R1",
          "strobes in reset", {dram_ras_n, dram_cas_n, dram_oe_n, dram_we_n}, 15);
      chk(!dram_dq_oe && !rd_valid, "R1", "drive and valid in reset",
          {dram_dq_oe, rd_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready, "R1", "ready after reset", req_ready, 1);
      chk(dram_ras_n && dram_cas_n, "R1", "strobes after reset", dram_ras_n, 1);
      // directed sweep: every word written once
      for (int a = 0; a < WORDS; a++)
         access(1'b1, ADDR_W'(a), DATA_W'(a) ^ 8'h5A);
      // extremes and read-after-write
      access(1'b0, '0, '0);
      access(1'b0, '1, '0);
      access(1'b1, '1, 8'hFF);
      access(1'b0, '1, '0);
      access(1'b1, '0, 8'h00);
      access(1'b0, '0, '0);
      // random back-to-back mix
      for (int i = 0; i < 600; i++)
         access(1'($urandom), ADDR_W'($urandom), DATA_W'($urandom));
      repeat (RFSH + 10) @(negedge clk);
      chk(n_ref >= cyc / (RFSH + 6) - 1, "R8", "refresh count under traffic",
          n_ref, cyc / (RFSH + 6));
      chk(n_ref > (1 << ROW_W), "R7", "refresh row wrapped", n_ref, 1 << ROW_W);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule